// File: doc/BRIEF.md
# Streaming Sobel Edge Detector

This block takes a raster-ordered stream of grayscale pixels, one pixel per cycle when `in_valid` is high. For every pixel it accepts, it emits one edge-strength pixel. Three rotating line memories hold the two previous image rows and the row being written. Together with the live input they supply a full 3x3 neighbourhood in a single cycle. Two kernel pipelines, one for horizontal gradient and one for vertical gradient, each multiply the nine window pixels by their coefficients. Each kernel then sums the products in three per-row adders followed by one final adder. The two directional sums are combined as |Gx| + |Gy| and clipped to the pixel range.

Output numbering: the accepted pixel at row r, column c yields the result for the window whose bottom-right corner is that pixel, so the window is centred at (r-1, c-1). If r < 2 or c < 2 the window is incomplete and the result is 0. A small raster state machine tracks rows:

- `FILL_A`: row 0. It moves to `FILL_B` on the last pixel of the row.
- `FILL_B`: row 1. It moves to `SWEEP` on the last pixel of the row.
- `SWEEP`: rows 2 and up. It returns to `FILL_A` on the last pixel of the frame.

Frames follow one another with no separate start marker; the frame size is set by parameters.

Top module: `sobel_stream`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_pix` is 0 until the first accepted pixel has passed through the pipeline.
- R2: Each accepted pixel produces exactly one output. If a pixel is accepted at rising edge n, `out_valid` is high after rising edge n+3 for one cycle. When no pixel was accepted, no output appears.
- R3: The three rows of the window are the current row, the previous row and the row before it. They come from three line memories of IMG_W entries that rotate at each row end.
- R4: The horizontal gradient uses the coefficients (-1,0,+1) on the top row, (-2,0,+2) on the middle row and (-1,0,+1) on the bottom row, with the left column first.
- R5: The vertical gradient uses (+1,+2,+1) on the top row, (0,0,0) on the middle row and (-1,-2,-1) on the bottom row.
- R6: A complete window outputs min(|Gx| + |Gy|, 255) for 8-bit pixels.
- R7: When the accepted pixel has column < 2 or row < 2, the output is 0.
- R8: The raster state machine steps `FILL_A` -> `FILL_B` -> `SWEEP` -> `FILL_A`. The first two rows of each new frame output 0, even though rows of the previous frame remain in the line memories.
- R9: Every directional sum stays within ±4·(2^PIX_W − 1) in a signed PIX_W+3-bit accumulator.
- R10: A cycle with `in_valid` low moves neither the window nor the row/column position. Results across input gaps match a gap-free stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present this cycle |
| in_pix | input | PIX_W | Grayscale input pixel |
| out_valid | output | 1 | Edge-strength pixel present |
| out_pix | output | PIX_W | Saturated edge strength |

## Verification
The last pixel of one frame and the first pixels of the next can be in flight together. In that situation, the final full windows of the old frame leave the pipeline while the state machine has already returned to `FILL_A` and is zeroing new border windows. Frames are sent back to back, with and without input gaps, so that these two functions meet in the same cycles. Every output cycle is compared against an arithmetic convolution of the frame held in the bench. Cycles with no output, and cycles where an output arrives with no input to account for it, are also judged.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    typedef enum logic [1:0] {
        FILL_A = 2'd0,
        FILL_B = 2'd1,
        SWEEP  = 2'd2
    } raster_e;

    // dir 0: horizontal gradient, dir 1: vertical gradient; r top..bottom, c left..right
    function automatic int kcoef(input int dir, input int r, input int c);
        int w;
        if (dir == 0) begin
            w = (r == 1) ? 2 : 1;
            return (c == 0) ? -w : ((c == 2) ? w : 0);
        end
        w = (c == 1) ? 2 : 1;
        return (r == 0) ? w : ((r == 2) ? -w : 0);
    endfunction

endpackage

// File: rtl/sobel_raster_ctl.sv
module sobel_raster_ctl
    import sobel_pkg::*;
#(
    parameter int IMG_W = 640,
    parameter int IMG_H = 480,
    localparam int CW = $clog2(IMG_W),
    localparam int RW = $clog2(IMG_H)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic [CW-1:0] col,
    output logic [1:0]    wsel,
    output logic          full_win
);

    raster_e       state_q, state_d;
    logic [CW-1:0] col_q;
    logic [RW-1:0] row_q;
    logic [1:0]    wsel_q;
    logic          row_end, frame_end;

    assign row_end   = in_valid && (col_q == CW'(IMG_W - 1));
    assign frame_end = row_end && (row_q == RW'(IMG_H - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FILL_A;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_A:  if (row_end)   state_d = FILL_B;
            FILL_B:  if (row_end)   state_d = SWEEP;
            SWEEP:   if (frame_end) state_d = FILL_A;
            default: state_d = FILL_A;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= '0;
            row_q  <= '0;
            wsel_q <= 2'd0;
        end else if (in_valid) begin
            if (row_end) begin
                col_q  <= '0;
                row_q  <= frame_end ? '0 : row_q + RW'(1);
                wsel_q <= (wsel_q == 2'd2) ? 2'd0 : wsel_q + 2'd1;
            end else begin
                col_q <= col_q + CW'(1);
            end
        end
    end

    always_comb begin
        col      = col_q;
        wsel     = wsel_q;
        full_win = (state_q == SWEEP) && (col_q >= CW'(2));
    end

    // R8
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FILL_A && row_end) |=> (state_q == FILL_B));

    // R8
    sweep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SWEEP && frame_end) |=> (state_q == FILL_A && col_q == '0 && row_q == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(col_q) && $stable(row_q) && $stable(state_q)));

    // R3
    rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_end |=> (wsel_q != $past(wsel_q) && wsel_q != 2'd3));

endmodule

// File: rtl/sobel_rowbufs.sv
module sobel_rowbufs #(
    parameter int PIX_W = 8,
    parameter int IMG_W = 640,
    localparam int CW = $clog2(IMG_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [PIX_W-1:0]   in_pix,
    input  logic [CW-1:0]      col,
    input  logic [1:0]         wsel,
    input  logic               full_win,
    output logic [9*PIX_W-1:0] win_flat,
    output logic               win_vld,
    output logic               win_ok
);

    logic [PIX_W-1:0] rd_all [3];
    logic [PIX_W-1:0] col_new [3];
    logic [PIX_W-1:0] win_q [3][3];
    logic [1:0]       mid_sel, top_sel;

    for (genvar b = 0; b < 3; b++) begin : g_line
        logic [PIX_W-1:0] mem [IMG_W];
        always_ff @(posedge clk) begin
            if (in_valid && wsel == 2'(b)) mem[col] <= in_pix;
        end
        assign rd_all[b] = mem[col];
    end

    always_comb begin
        mid_sel    = (wsel == 2'd0) ? 2'd2 : wsel - 2'd1;
        top_sel    = (wsel == 2'd2) ? 2'd0 : wsel + 2'd1;
        col_new[0] = rd_all[top_sel];
        col_new[1] = rd_all[mid_sel];
        col_new[2] = in_pix;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < 3; r++)
                for (int c = 0; c < 3; c++) win_q[r][c] <= '0;
            win_vld <= 1'b0;
            win_ok  <= 1'b0;
        end else begin
            win_vld <= in_valid;
            win_ok  <= in_valid && full_win;
            if (in_valid) begin
                for (int r = 0; r < 3; r++) begin
                    win_q[r][0] <= win_q[r][1];
                    win_q[r][1] <= win_q[r][2];
                    win_q[r][2] <= col_new[r];
                end
            end
        end
    end

    for (genvar k = 0; k < 9; k++) begin : g_flat
        assign win_flat[k*PIX_W +: PIX_W] = win_q[k/3][k%3];
    end

    // R10
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(win_flat));

endmodule

// File: rtl/sobel_kernel.sv
module sobel_kernel
    import sobel_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int DIR   = 0,
    localparam int ACC_W = PIX_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [9*PIX_W-1:0]      win_flat,
    output logic signed [ACC_W-1:0] total
);

    localparam logic signed [ACC_W-1:0] LIM = ACC_W'(4 * ((1 << PIX_W) - 1));

    logic signed [ACC_W-1:0] prod_q [9];
    logic signed [ACC_W-1:0] rows_q [3];

    for (genvar k = 0; k < 9; k++) begin : g_mul
        localparam logic signed [ACC_W-1:0] KC = ACC_W'(kcoef(DIR, k / 3, k % 3));
        logic signed [ACC_W-1:0] pix_ext;
        assign pix_ext = $signed({{(ACC_W-PIX_W){1'b0}}, win_flat[k*PIX_W +: PIX_W]});
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod_q[k] <= '0;
            else        prod_q[k] <= KC * pix_ext;
        end
    end

    for (genvar r = 0; r < 3; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rows_q[r] <= '0;
            else        rows_q[r] <= prod_q[3*r] + prod_q[3*r+1] + prod_q[3*r+2];
        end
    end

    assign total = rows_q[0] + rows_q[1] + rows_q[2];

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (total <= LIM) && (total >= -LIM));

endmodule

// File: rtl/sobel_mag.sv
module sobel_mag #(
    parameter int PIX_W = 8,
    localparam int ACC_W = PIX_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] gx,
    input  logic signed [ACC_W-1:0] gy,
    input  logic                    vld,
    input  logic                    ok,
    output logic                    out_valid,
    output logic [PIX_W-1:0]        out_pix
);

    localparam logic [ACC_W:0] MAXP = (ACC_W+1)'((1 << PIX_W) - 1);

    logic [ACC_W-1:0] ax, ay;
    logic [ACC_W:0]   sum;
    logic [PIX_W-1:0] clipped;

    always_comb begin
        ax      = gx[ACC_W-1] ? ACC_W'(-gx) : ACC_W'(gx);
        ay      = gy[ACC_W-1] ? ACC_W'(-gy) : ACC_W'(gy);
        sum     = {1'b0, ax} + {1'b0, ay};
        clipped = (sum > MAXP) ? MAXP[PIX_W-1:0] : sum[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= vld;
            out_pix   <= (vld && ok) ? clipped : '0;
        end
    end

    // R7
    border_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !ok) |=> (out_valid && out_pix == '0));

    // R6
    sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && ok && !gx[ACC_W-1] && ({1'b0, gx} >= MAXP)) |=> (out_pix == MAXP[PIX_W-1:0]));

endmodule

// File: rtl/sobel_stream.sv
module sobel_stream #(
    parameter int PIX_W = 8,
    parameter int IMG_W = 640,
    parameter int IMG_H = 480
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);

    localparam int CW    = $clog2(IMG_W);
    localparam int ACC_W = PIX_W + 3;

    logic [CW-1:0]           col;
    logic [1:0]              wsel;
    logic                    full_win;
    logic [9*PIX_W-1:0]      win_flat;
    logic                    win_vld, win_ok;
    logic signed [ACC_W-1:0] g_sum [2];
    logic [1:0]              vld_p, ok_p;

    sobel_raster_ctl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .col(col), .wsel(wsel), .full_win(full_win)
    );

    sobel_rowbufs #(.PIX_W(PIX_W), .IMG_W(IMG_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .col(col), .wsel(wsel), .full_win(full_win),
        .win_flat(win_flat), .win_vld(win_vld), .win_ok(win_ok)
    );

    for (genvar d = 0; d < 2; d++) begin : g_dir
        sobel_kernel #(.PIX_W(PIX_W), .DIR(d)) u_kern (
            .clk(clk), .rst_n(rst_n), .win_flat(win_flat), .total(g_sum[d])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_p <= '0;
            ok_p  <= '0;
        end else begin
            vld_p <= {vld_p[0], win_vld};
            ok_p  <= {ok_p[0], win_ok};
        end
    end

    sobel_mag #(.PIX_W(PIX_W)) u_mag (
        .clk(clk), .rst_n(rst_n), .gx(g_sum[0]), .gy(g_sum[1]),
        .vld(vld_p[1]), .ok(ok_p[1]),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##4 out_valid);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##4 !out_valid);

endmodule

// File: tb/sobel_stream_bench.sv
module sobel_stream_bench;

    localparam int W = 8;
    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_pix = '0;
    logic       out_valid;
    logic [7:0] out_pix;

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    chk_on = 0;
    bit    done = 0;
    int    img [H][W];
    int    exp_q [$];
    int    due_q [$];
    string tag_q [$];
    logic [31:0] lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    sobel_stream #(.PIX_W(8), .IMG_W(W), .IMG_H(H)) u_sobel_stream (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic int rnd();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'(lcg[23:16]);
    endfunction

    function automatic int ref_mag(int r, int c);
        int gx = 0, gy = 0, p, wx, wy, s;
        for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 3; j++) begin
                p  = img[r-2+i][c-2+j];
                wx = ((j == 0) ? -1 : (j == 2) ? 1 : 0) * ((i == 1) ? 2 : 1);
                wy = ((i == 0) ? 1 : (i == 2) ? -1 : 0) * ((j == 1) ? 2 : 1);
                gx += wx * p;
                gy += wy * p;
            end
        end
        s = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
        return (s > 255) ? 255 : s;
    endfunction

    task automatic send_frame(int pat, string tag, bit gaps, bit first);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                case (pat)
                    0: img[r][c] = (r * 20 + c * 7) & 255;
                    1: img[r][c] = (c < 4) ? 10 : 250;
                    2: img[r][c] = (r < 3) ? 0 : 200;
                    3: img[r][c] = rnd();
                    4: img[r][c] = rnd() & 31;
                    default: img[r][c] = ((r * 3 + c * 5) * 37) & 255;
                endcase
            end
        end
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                if (gaps) begin
                    while (rnd() < 90) begin
                        @(negedge clk);
                        in_valid = 1'b0;
                    end
                end
                @(negedge clk);
                in_valid = 1'b1;
                in_pix   = 8'(img[r][c]);
                due_q.push_back(cyc + 4);
                if (r < 2 || c < 2) begin
                    exp_q.push_back(0);
                    tag_q.push_back((r < 2 && !first) ? "R8" : "R7");
                end else begin
                    exp_q.push_back(ref_mag(r, c));
                    tag_q.push_back(tag);
                end
            end
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) begin
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                total++;
                if (!out_valid || int'(out_pix) != exp_q[0]) begin
                    bad++;
                    $display("FAIL %s: valid=%0b pix=%0d expected valid=1 pix=%0d",
                             tag_q[0], out_valid, out_pix, exp_q[0]);
                end
                void'(due_q.pop_front());
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end else if (out_valid) begin
                total++;
                bad++;
                $display("FAIL R2: valid=1 pix=%0d expected valid=0", out_pix);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1;
            bad++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        total++;
        if (out_valid !== 1'b0 || out_pix !== 8'd0) begin
            bad++;
            $display("FAIL R1: valid=%0b pix=%0d expected valid=0 pix=0", out_valid, out_pix);
        end
        rst_n = 1'b1;
        chk_on = 1;
        repeat (6) @(negedge clk);
        // R1: outputs quiet after release with no input
        total++;
        if (out_valid !== 1'b0 || out_pix !== 8'd0) begin
            bad++;
            $display("FAIL R1: valid=%0b pix=%0d expected valid=0 pix=0", out_valid, out_pix);
        end
        send_frame(0, "R3", 0, 1);
        send_frame(1, "R4", 0, 0);
        send_frame(2, "R5", 0, 0);
        send_frame(3, "R6", 1, 0);
        send_frame(4, "R10", 1, 0);
        send_frame(5, "R6", 0, 0);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (12) @(negedge clk);
        // R2: every accepted pixel produced its output
        total++;
        if (due_q.size() != 0) begin
            bad++;
            $display("FAIL R2: pending=%0d expected 0", due_q.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule